// File: doc/BRIEF.md
# Serial-In Parallel-Out Register with Storage Latch

This block accepts a serial bit stream on its own rising-edge shift clock and moves it through a chain of flip-flops. A second rising-edge clock copies the whole chain into a storage register in one step. The storage register drives the parallel outputs. The parallel outputs can be released to high impedance through an active-low output enable. Releasing them leaves the stored word as it was.

An active-low clear empties the shift chain at once, with no clock needed. It does not touch the storage register. The last shift stage also drives a cascade output that is never released to high impedance. Feeding this output into the serial input of a second copy gives a chain twice as long, and that chain is loaded with one burst of shift clocks and published with a single storage clock.

The two clocks may be wired together. In that case the storage register always shows the chain as it stood one edge before.

Top module: `sipo_latch_reg`

## Requirements
- R1: On a rising edge of `shift_clk` with `clr_n` high, stage 0 loads `ser_in` and stage i+1 loads the previous value of stage i. The old top stage is discarded.
- R2: `cascade_out` always equals the top shift stage (bit WIDTH-1), whatever `oe_n` is. Two copies chained through it behave as one 2*WIDTH-bit chain. The first copy's stage k is chain position k and the second copy's stage k is position WIDTH+k.
- R3: While `clr_n` is low, every shift stage reads 0. This holds before any clock edge and over any number of `shift_clk` edges. Clear takes priority over a coincident edge, and the storage register keeps its contents.
- R4: A rising edge of `store_clk` copies all shift stages into the storage register. With `oe_n` low, `par_out[i]` shows stored bit i.
- R5: The storage register keeps its value across `shift_clk` edges when no `store_clk` edge occurs.
- R6: With `oe_n` high, every bit of `par_out` is high impedance. Driving `oe_n` low again shows the unchanged stored word.
- R7: When `store_clk` and `shift_clk` are the same signal, after each edge the storage register holds the shift contents from just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Rising-edge clock for the shift chain |
| store_clk | input | 1 | Rising-edge clock for the storage register |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain only |
| oe_n | input | 1 | Active-low enable for the parallel outputs |
| par_out | output | WIDTH | Storage register outputs, high impedance when disabled |
| cascade_out | output | 1 | Top shift stage, always driven, for chaining |

## Verification
Two pairs of functions can act in the same cycle. The first pair is clear and shift. The bench holds `clr_n` low across live `shift_clk` edges with `ser_in` at 1, then requires the cascade outputs to stay 0 and the published word to stay the same. The second pair is shift and store. With the clocks tied, both act on every edge, and the bench requires the published word to lag the chain by exactly one edge. A behavioural queue model of the 16-bit two-copy chain and its two stored words is compared on every clock. The high-impedance state is judged through a pull-up net on one copy and a pull-down net on the other, chosen so that a driven word could not satisfy both.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

   localparam int SIPO_DEFAULT_WIDTH = 8;

   typedef enum logic {
      DRV_ACTIVE = 1'b0,
      DRV_FLOAT  = 1'b1
   } drv_mode_e;

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             din,
   output logic [WIDTH-1:0] stages
);

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_stage
         logic d;
         logic q;
         if (i == 0) begin : g_head
            assign d = din;
         end else begin : g_body
            assign d = stages[i-1];
         end
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q <= 1'b0;
            else        q <= d;
         end
         assign stages[i] = q;
      end
   endgenerate

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv
   import sipo_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] y
);

   localparam logic [WIDTH-1:0] FLOAT_WORD = {WIDTH{1'bz}};

   drv_mode_e mode;

   assign mode = oe_n ? DRV_FLOAT : DRV_ACTIVE;
   assign y    = (mode == DRV_FLOAT) ? FLOAT_WORD : d;

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
   import sipo_pkg::*;
#(
   parameter int WIDTH = SIPO_DEFAULT_WIDTH
) (
   input  logic             ser_in,
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             clr_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_out,
   output logic             cascade_out
);

   localparam int TOP_STAGE = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("sipo_latch_reg: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] shift_q;
   logic [WIDTH-1:0] store_q;

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk    (shift_clk),
      .clr_n  (clr_n),
      .din    (ser_in),
      .stages (shift_q)
   );

   sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
      .clk (store_clk),
      .d   (shift_q),
      .q   (store_q)
   );

   sipo_out_drv #(.WIDTH(WIDTH)) u_drv (
      .oe_n (oe_n),
      .d    (store_q),
      .y    (par_out)
   );

   assign cascade_out = shift_q[TOP_STAGE];

endmodule

// File: rtl/sipo_latch_reg_chk.sv
module sipo_latch_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             shift_clk,
   input logic             store_clk,
   input logic             clr_n,
   input logic             ser_in,
   input logic [WIDTH-1:0] shift_q,
   input logic [WIDTH-1:0] store_q
);

   assert_head_load_R1: assert property (@(posedge shift_clk) disable iff (!clr_n)
      1'b1 |=> shift_q[0] == $past(ser_in));

   assert_advance_R1: assert property (@(posedge shift_clk) disable iff (!clr_n)
      1'b1 |=> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]));

   assert_clear_wins_R3: assert property (@(posedge shift_clk)
      !clr_n |-> shift_q == '0);

   assert_capture_R4: assert property (@(posedge store_clk)
      1'b1 |=> store_q == $past(shift_q));

endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .shift_clk (shift_clk),
   .store_clk (store_clk),
   .clr_n     (clr_n),
   .ser_in    (ser_in),
   .shift_q   (shift_q),
   .store_q   (store_q)
);

// File: tb/sipo_latch_reg_bench.sv
module sipo_latch_reg_bench;

   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic sh_en = 1'b0, st_en = 1'b0, tie = 1'b0;
   logic din = 1'b0, clr_n = 1'b1, oe_n = 1'b1;
   logic started = 1'b0, done = 1'b0;
   int   nchecks = 0, nfail = 0;

   wire shift_clk = clk & sh_en;
   wire store_clk = clk & (tie ? sh_en : st_en);

   tri1 [W-1:0] pa;
   tri0 [W-1:0] pb;
   wire casc_a, casc_b;

   sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg (
      .ser_in(din), .shift_clk(shift_clk), .store_clk(store_clk),
      .clr_n(clr_n), .oe_n(oe_n), .par_out(pa), .cascade_out(casc_a));

   sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg_nxt (
      .ser_in(casc_a), .shift_clk(shift_clk), .store_clk(store_clk),
      .clr_n(clr_n), .oe_n(oe_n), .par_out(pb), .cascade_out(casc_b));

   // behavioural model: queue front is stage 0 of the first copy
   bit chain[$];
   logic [W-1:0] ms_a, ms_b;
   bit st_valid = 0;

   initial begin
      for (int k = 0; k < 2*W; k++) chain.push_back(1'b0);
   end

   always @(posedge clk) begin
      if (tie ? sh_en : st_en) begin
         for (int k = 0; k < W; k++) begin
            ms_a[k] = chain[k];
            ms_b[k] = chain[W+k];
         end
         st_valid = 1;
      end
      if (sh_en && clr_n) begin
         chain.push_front(din);
         void'(chain.pop_back());
      end
   end

   always @(negedge clr_n) begin
      for (int k = 0; k < 2*W; k++) chain[k] = 1'b0;
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchecks++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #3;
      if (started && !done) begin
         chk("R1/R2 cascade first", {15'd0, casc_a}, {15'd0, chain[W-1]});
         chk("R1/R2 cascade second", {15'd0, casc_b}, {15'd0, chain[2*W-1]});
         if (oe_n) begin
            chk("R6 float first", {8'd0, pa}, 16'h00FF);
            chk("R6 float second", {8'd0, pb}, 16'h0000);
         end else if (st_valid) begin
            chk(tie ? "R7 lag first" : "R4/R5 word first", {8'd0, pa}, {8'd0, ms_a});
            chk(tie ? "R7 lag second" : "R4/R5 word second", {8'd0, pb}, {8'd0, ms_b});
         end
      end
   end

   task automatic shift_word(input logic [15:0] p, input int nbits);
      for (int j = 0; j < nbits; j++) begin
         @(negedge clk);
         sh_en = 1'b1;
         din   = p[15-j];
      end
      @(negedge clk);
      sh_en = 1'b0;
   endtask

   task automatic store_pulse();
      @(negedge clk);
      st_en = 1'b1;
      @(negedge clk);
      st_en = 1'b0;
   endtask

   localparam logic [15:0] PAT_A = 16'hA5C3;
   localparam logic [15:0] PAT_T = 16'h3C96;

   initial begin
      #2 clr_n = 1'b0;
      repeat (2) @(negedge clk);
      started = 1'b1;
      #1;
      chk("R3 reset cascade", {15'd0, casc_a}, 16'd0);
      chk("R6 reset float", {pb, pa}, 16'h00FF);
      @(negedge clk);
      clr_n = 1'b1;

      shift_word(PAT_A, 16);
      chk("R2 chained top stage", {14'd0, casc_b, casc_a}, {14'd0, PAT_A[15], PAT_A[7]});

      oe_n = 1'b0;
      store_pulse();
      #1;
      chk("R4 first word", {8'd0, pa}, {8'd0, PAT_A[7:0]});
      chk("R4 second word", {8'd0, pb}, {8'd0, PAT_A[15:8]});

      shift_word(16'hFFFF, 5);
      #1;
      chk("R5 hold across shifts", {pb, pa}, PAT_A);

      @(negedge clk);
      oe_n = 1'b1;
      #1;
      chk("R6 float", {pb, pa}, 16'h00FF);
      chk("R2 cascade while disabled", {15'd0, casc_a}, {15'd0, chain[W-1]});
      @(negedge clk);
      oe_n = 1'b0;
      #1;
      chk("R6 word unchanged", {pb, pa}, PAT_A);

      @(negedge clk);
      clr_n = 1'b0;
      sh_en = 1'b1;
      din   = 1'b1;
      #1;
      chk("R3 async clear", {14'd0, casc_b, casc_a}, 16'd0);
      repeat (2) @(negedge clk);
      chk("R3 clear over edges", {14'd0, casc_b, casc_a}, 16'd0);
      chk("R3 storage untouched", {pb, pa}, PAT_A);
      sh_en = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
      store_pulse();
      #1;
      chk("R3/R4 cleared chain stored", {pb, pa}, 16'h0000);

      @(negedge clk);
      tie = 1'b1;
      shift_word(PAT_T, 16);
      #1;
      chk("R7 tied first word", {8'd0, pa}, {8'd0, PAT_T[8:1]});
      chk("R7 tied second word", {9'd0, pb[6:0]}, {9'd0, PAT_T[15:9]});
      tie = 1'b0;

      shift_word(16'h5A00, 8);
      store_pulse();
      #1;
      chk("R4 partial refill", {pb, pa}, {PAT_T[7:0], 8'h5A});

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         nchecks++;
         nfail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   end

endmodule